// File: doc/BRIEF.md
# Preemptive Priority Next-Interrupt Selector

This block looks at three per-interrupt vectors (a request-pending vector, an enable vector and a packed array of 4-bit priority values) and works out which external interrupt should be handled next. An interrupt is a candidate only when it is both pending and enabled. The winner is the candidate with the highest priority. When several candidates share that priority, the lowest interrupt number wins.

Two separate preemption thresholds filter the candidates. The current threshold gates the single machine external interrupt pending line that feeds the core's trap logic. The previous threshold filters the next-interrupt result word that software reads. That word carries the winning number shifted left by two, so software can use it directly as a byte offset into a table of 32-bit handler addresses. When there is no winner, only the most significant bit of the word is set.

A read strobe marks the moment software reads the result. If the read returns a winner, the block issues a one-cycle claim pulse with the interrupt number, which is used to clear that interrupt's software-forced request. A read that also carries the update flag issues a one-cycle update pulse to the surrounding context logic.

Top module: `nirq_select`

## Requirements
- R1: Only an interrupt whose pending bit and enable bit are both 1 can be selected. A pending interrupt that is not enabled never appears in the result and never raises the pending line.
- R2: Among candidates, the one with the numerically largest 4-bit priority is selected (priority of interrupt i is `irq_prio[4*i+3:4*i]`).
- R3: When several candidates share the largest priority, the lowest-numbered one is selected.
- R4: With a winner, `next_word[31]` is 0, `next_word[IDX_W+1:2]` holds the winning number, and every other bit is 0.
- R5: With no qualifying candidate, `next_word` is exactly 32'h8000_0000.
- R6: For the result word, a candidate whose priority is below `ppreempt` (5-bit unsigned compare) is treated as not pending. A value of 16 filters out every interrupt.
- R7: `mext_pending` is 1 exactly when some pending and enabled interrupt has a priority not below `preempt`. This holds regardless of `ppreempt`, and a value of 16 holds the line low.
- R8: The cycle after a clock edge that sees `rd_en` high while `next_word[31]` is 0, `claim_valid` is 1 and `claim_irq` holds the number that was read. Otherwise `claim_valid` is 0. This does not depend on `upd_req`.
- R9: The cycle after a clock edge that sees `rd_en` and `upd_req` both high, `ctx_update` is 1, whether or not a winner existed. Otherwise it is 0.
- R10: While `rst_n` is low, and in the first cycle after reset, `claim_valid` and `ctx_update` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pending | input | NUM_IRQ | Level-sensitive request pending per interrupt |
| irq_enable | input | NUM_IRQ | Enable per interrupt |
| irq_prio | input | NUM_IRQ*4 | Packed 4-bit priority per interrupt |
| preempt | input | 5 | Current preemption threshold (gates mext_pending) |
| ppreempt | input | 5 | Previous preemption threshold (filters next_word) |
| rd_en | input | 1 | Software read of the next-interrupt word this cycle |
| upd_req | input | 1 | Update flag accompanying the read (write data bit 0) |
| next_word | output | 32 | Result word: no-IRQ flag in bit 31, number in bits IDX_W+1:2 |
| mext_pending | output | 1 | Machine external interrupt pending line |
| claim_valid | output | 1 | One-cycle pulse after a read that returned a winner |
| claim_irq | output | IDX_W | Interrupt number claimed by that read |
| ctx_update | output | 1 | One-cycle pulse after a read with the update flag |

## Verification
A wrong comparison or a broken tie-break in the arbitration shows up immediately on `next_word`, because the result is combinational from the vectors. A selection that is wrong by one position in the index chain moves the number field by four byte addresses. A swapped use of the two thresholds appears as `mext_pending` and `next_word` disagreeing when the two thresholds differ. A fault in the claim or update registers shows one cycle after the read strobe, as a missing pulse, an extra pulse or a stale number.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int PRIO_W = 4;
  localparam int THR_W  = PRIO_W + 1;
  localparam int WORD_W = 32;

  // Priority passes a threshold when not below it (threshold one bit wider)
  function automatic logic thr_pass(input logic [PRIO_W-1:0] p,
                                    input logic [THR_W-1:0] thr);
    return {1'b0, p} >= thr;
  endfunction

  // Build the result word: number shifted by two, or the lone no-IRQ bit
  function automatic logic [WORD_W-1:0] fmt_word(input logic found,
                                                 input logic [WORD_W-3:0] idx);
    logic [WORD_W-1:0] w;
    if (found) w = {idx, 2'b00};
    else       w = {1'b1, {(WORD_W-1){1'b0}}};
    return w;
  endfunction
endpackage

// File: rtl/nirq_qualify.sv
module nirq_qualify
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]        irq_pending,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [THR_W-1:0]          preempt,
  input  logic [THR_W-1:0]          ppreempt,
  output logic [NUM_IRQ-1:0]        cand_next,
  output logic [NUM_IRQ-1:0]        cand_line
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_q
    logic live;
    assign live         = irq_pending[i] & irq_enable[i];
    assign cand_next[i] = live & thr_pass(irq_prio[i*PRIO_W +: PRIO_W], ppreempt);
    assign cand_line[i] = live & thr_pass(irq_prio[i*PRIO_W +: PRIO_W], preempt);
  end
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx
);
  logic [PRIO_W-1:0] best;

  // Ascending scan; strict compare keeps the lowest index on a tie
  always_comb begin
    found   = 1'b0;
    best    = '0;
    win_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!found || irq_prio[i*PRIO_W +: PRIO_W] > best)) begin
        found   = 1'b1;
        best    = irq_prio[i*PRIO_W +: PRIO_W];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/nirq_select.sv
module nirq_select
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_pending,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [THR_W-1:0]          preempt,
  input  logic [THR_W-1:0]          ppreempt,
  input  logic                      rd_en,
  input  logic                      upd_req,
  output logic [WORD_W-1:0]         next_word,
  output logic                      mext_pending,
  output logic                      claim_valid,
  output logic [IDX_W-1:0]          claim_irq,
  output logic                      ctx_update
);
  logic [NUM_IRQ-1:0] cand_next;
  logic [NUM_IRQ-1:0] cand_line;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic               claim_ev;
  logic               update_ev;

  nirq_qualify #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .irq_prio    (irq_prio),
    .preempt     (preempt),
    .ppreempt    (ppreempt),
    .cand_next   (cand_next),
    .cand_line   (cand_line)
  );

  nirq_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .cand     (cand_next),
    .irq_prio (irq_prio),
    .found    (found),
    .win_idx  (win_idx)
  );

  assign next_word    = fmt_word(found, (WORD_W-2)'(win_idx));
  assign mext_pending = |cand_line;
  assign claim_ev     = rd_en & found;
  assign update_ev    = rd_en & upd_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_valid <= 1'b0;
      claim_irq   <= '0;
      ctx_update  <= 1'b0;
    end else begin
      claim_valid <= claim_ev;
      ctx_update  <= update_ev;
      if (claim_ev) claim_irq <= win_idx;
    end
  end
endmodule

// File: rtl/nirq_select_chk.sv
module nirq_select_chk
  import nirq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_IRQ-1:0]        irq_pending,
  input logic [NUM_IRQ-1:0]        irq_enable,
  input logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input logic [THR_W-1:0]          ppreempt,
  input logic                      rd_en,
  input logic                      upd_req,
  input logic [WORD_W-1:0]         next_word,
  input logic                      mext_pending,
  input logic                      claim_valid,
  input logic [IDX_W-1:0]          claim_irq,
  input logic                      ctx_update,
  input logic [IDX_W-1:0]          win_idx
);
  logic [IDX_W-1:0] rd_idx;
  assign rd_idx = next_word[IDX_W+1:2];

  assert_fmt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !next_word[31] |-> (next_word[1:0] == 2'b00 && next_word[30:IDX_W+2] == '0));

  assert_noirq_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    next_word[31] |-> next_word[30:0] == '0);

  assert_winner_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !next_word[31] |-> (irq_pending[rd_idx] && irq_enable[rd_idx]));

  assert_winner_thr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !next_word[31] |-> ({1'b0, irq_prio[int'(rd_idx)*PRIO_W +: PRIO_W]} >= ppreempt));

  assert_line_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mext_pending |-> |(irq_pending & irq_enable));

  assert_claim_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |-> ($past(rd_en) && !$past(next_word[31]) && claim_irq == $past(win_idx)));

  assert_update_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_update |-> $past(rd_en && upd_req));
endmodule

bind nirq_select nirq_select_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_pending  (irq_pending),
  .irq_enable   (irq_enable),
  .irq_prio     (irq_prio),
  .ppreempt     (ppreempt),
  .rd_en        (rd_en),
  .upd_req      (upd_req),
  .next_word    (next_word),
  .mext_pending (mext_pending),
  .claim_valid  (claim_valid),
  .claim_irq    (claim_irq),
  .ctx_update   (ctx_update),
  .win_idx      (win_idx)
);

// File: tb/nirq_select_test.sv
module nirq_select_test;
  localparam int N  = 32;
  localparam int PW = 4;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    pend = '0, en = '0;
  logic [N*PW-1:0] prio = '0;
  logic [4:0]      pre = '0, ppre = '0;
  logic            rd = 1'b0, upd = 1'b0;
  logic [31:0]     word;
  logic            line, cv, cu;
  logic [IW-1:0]   cirq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0]   word;
    logic          line;
    logic          cv;
    logic [IW-1:0] cirq;
    logic          cu;
    string         tag;
  } exp_t;
  exp_t q[$];
  logic [IW-1:0] last_claim = '0;

  always #2 clk = ~clk;

  nirq_select #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pending(pend), .irq_enable(en),
    .irq_prio(prio), .preempt(pre), .ppreempt(ppre), .rd_en(rd),
    .upd_req(upd), .next_word(word), .mext_pending(line),
    .claim_valid(cv), .claim_irq(cirq), .ctx_update(cu)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Model: scan priority levels from the top, indices from the bottom
  task automatic drive(input string tag, input logic [N-1:0] p, input logic [N-1:0] e,
                       input logic [N*PW-1:0] pr, input logic [4:0] cur,
                       input logic [4:0] prev, input logic r, input logic u);
    exp_t x;
    bit hit = 0;
    int sel = 0;
    @(negedge clk);
    pend = p; en = e; prio = pr; pre = cur; ppre = prev; rd = r; upd = u;
    for (int lv = 15; lv >= 0 && !hit; lv--)
      for (int i = 0; i < N && !hit; i++)
        if (p[i] && e[i] && pr[i*PW +: PW] == lv && lv >= prev) begin hit = 1; sel = i; end
    x.word = hit ? (32'(sel) * 4) : 32'h8000_0000;
    x.line = 1'b0;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && int'(pr[i*PW +: PW]) >= int'(cur)) x.line = 1'b1;
    x.cv   = r && hit;
    if (x.cv) last_claim = IW'(sel);
    x.cirq = last_claim;
    x.cu   = r && u;
    x.tag  = tag;
    q.push_back(x);
  endtask

  // Monitor: one edge after each drive, combinational and registered outputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(x.tag, "next_word", word, x.word);
        chk(x.tag, "mext_pending", 32'(line), 32'(x.line));
        chk(x.tag, "claim_valid", 32'(cv), 32'(x.cv));
        if (x.cv) chk(x.tag, "claim_irq", 32'(cirq), 32'(x.cirq));
        chk(x.tag, "ctx_update", 32'(cu), 32'(x.cu));
      end
    end
  end

  function automatic logic [N*PW-1:0] setp(input logic [N*PW-1:0] v, input int i, input int p);
    logic [N*PW-1:0] r = v;
    r[i*PW +: PW] = PW'(p);
    return r;
  endfunction

  initial begin
    logic [N*PW-1:0] pv;
    rd = 1'b1; upd = 1'b1; pend = '1; en = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "claim_valid in reset", 32'(cv), 0);
    chk("R10", "ctx_update in reset", 32'(cu), 0);
    @(negedge clk);
    rd = 1'b0; upd = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10", "claim_valid after reset", 32'(cv), 0);
    chk("R10", "ctx_update after reset", 32'(cu), 0);

    // R1 / R4: single candidate
    pv = setp('0, 5, 3);
    drive("R4", 32'h20, 32'h20, pv, 0, 0, 0, 0);
    // R1: pending but disabled
    drive("R1", 32'h20, 32'h00, pv, 0, 0, 0, 0);
    // R5: nothing pending
    drive("R5", '0, '1, pv, 0, 0, 0, 0);
    // R2: higher priority wins over lower index
    pv = setp(setp('0, 2, 4), 9, 11);
    drive("R2", 32'h204, 32'h204, pv, 0, 0, 0, 0);
    // R3: tie goes to lowest index
    pv = setp(setp(setp('0, 3, 7), 12, 7), 1, 2);
    drive("R3", 32'h100A, 32'h100A, pv, 0, 0, 0, 0);
    // R4: top index boundary
    pv = setp('0, 31, 15);
    drive("R4", 32'h8000_0000, 32'h8000_0000, pv, 0, 0, 0, 0);
    // R6: previous threshold filters the result only
    pv = setp(setp('0, 1, 3), 6, 9);
    drive("R6", 32'h42, 32'h42, pv, 0, 10, 0, 0);
    drive("R6", 32'h42, 32'h42, pv, 0, 8, 0, 0);
    drive("R6", 32'h42, 32'h42, pv, 0, 16, 0, 0);
    // R7: current threshold gates the line, independent of result
    drive("R7", 32'h42, 32'h42, pv, 10, 0, 0, 0);
    drive("R7", 32'h42, 32'h42, pv, 9, 16, 0, 0);
    drive("R7", 32'h42, 32'h42, pv, 16, 0, 0, 0);
    drive("R7", 32'h42, 32'h02, pv, 4, 0, 0, 0);
    // R8: claim on a winning read, none on an empty read
    drive("R8", 32'h42, 32'h42, pv, 0, 0, 1, 0);
    drive("R8", 32'h42, 32'h42, pv, 0, 0, 0, 0);
    drive("R8", 32'h42, 32'h42, pv, 0, 16, 1, 0);
    // R9: update pulse with and without a winner
    drive("R9", 32'h42, 32'h42, pv, 0, 0, 1, 1);
    drive("R9", '0, '0, pv, 0, 0, 1, 1);
    drive("R9", 32'h42, 32'h42, pv, 0, 0, 0, 1);
    // R2: random mixes
    for (int k = 0; k < 60; k++) begin
      logic [N*PW-1:0] rp;
      for (int i = 0; i < N; i++) rp[i*PW +: PW] = PW'($urandom);
      drive("R2", N'($urandom), N'($urandom), rp, 5'($urandom_range(0, 16)),
            5'($urandom_range(0, 16)), 1'($urandom), 1'($urandom));
    end
    @(negedge clk); rd = 1'b0; upd = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule